// File: doc/BRIEF.md
# Phase-Offset Programmable Clock Divider

This block holds a set of clock channel dividers that share one input clock. Each channel drives a square wave whose high and low phases are each set in whole input-clock cycles. A coarse phase delay, also counted in input cycles, sets when the first rising edge appears after a synchronization event. With distinct delays, channels that run from the same clock can be placed at fixed output-to-output skews.

Synchronization is requested either by a pin-level request, which is already synchronized to the divider clock, or by a software request bit. The two requests are ORed. While a request is high, every channel that is not excluded has its output forced low and its divide ratio and delay loaded from the live configuration inputs. When the request is released, those channels start counting from the loaded preset, so they stay aligned with each other. A channel with its exclude bit set ignores both requests and runs on undisturbed. Changing the configuration inputs has no effect on a channel until its next synchronization.

Top module: `phase_clk_div`

## Requirements
- R1: While rst_ni is low, every bit of clk_o is 0. Reset clears the held high and low counts of every channel to 0.
- R2: A channel whose held high count and low count are both 0 toggles on every clock edge, which gives the input clock divided by 2 at a 50% duty cycle. After reset release with no sync, each channel goes high at the first edge.
- R3: Once running, a channel's output stays high for hi+1 cycles and then low for lo+1 cycles, and repeats this pattern. Here hi is the 4-bit field hi_cnt_i[4c+3:4c] and lo is the 4-bit field lo_cnt_i[4c+3:4c], as captured at the last sync.
- R4: At every clock edge that samples sync_i high, each channel c with excl_i[c]=0 captures its configuration, and its clk_o[c] is 0 after that edge.
- R5: The phase value is 16*start_hi_i[c] + phase_i[4c+3:4c]. Let k be the first edge that samples the request low. A channel with phase value 0 goes high at edge k. A channel with a phase value of 15 or less goes high that many edges later.
- R6: For a phase value of 16 or more, the first rising edge is delayed by (phase value - 16 + lo + 1) edges after edge k.
- R7: Changes to hi_cnt_i, lo_cnt_i, phase_i and start_hi_i while no sync is applied to a channel leave its output waveform unchanged.
- R8: A channel with excl_i[c]=1 ignores both sync requests. Its waveform continues without a break and keeps the settings it captured last.
- R9: sync_sw_i high has the same effect as sync_i high, including the capture and the phase alignment that follow its release.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Divider input clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| sync_i | input | 1 | Synchronous sync request from the pin, active high |
| sync_sw_i | input | 1 | Software sync request, active high |
| excl_i | input | NUM_CH | Per-channel exclusion from sync |
| start_hi_i | input | NUM_CH | Per-channel start-high bit (bit 4 of the phase value) |
| phase_i | input | NUM_CH*4 | Per-channel 4-bit phase offset, channel c in bits [4c+3:4c] |
| hi_cnt_i | input | NUM_CH*4 | Per-channel high count, high phase = value+1 cycles |
| lo_cnt_i | input | NUM_CH*4 | Per-channel low count, low phase = value+1 cycles |
| clk_o | output | NUM_CH | Divided clock outputs, one register stage per channel |

## Verification
Every output is a single register. A sync request sampled high at an edge therefore shows as a low output right after that same edge. A zero-offset channel shows its first high right after the first edge that samples the request low. A channel with delay D shows its first high D edges later. The bench drives all inputs and samples clk_o on the falling edge. It counts sample t = 1 as the falling edge after that first low-sampled edge, and expects output sample t to equal 1 exactly when t > D and ((t-1-D) mod (hi+lo+2)) <= hi. The bench compares every sample against this formula for each channel. The formula covers the hold, the first edge, the phase delay and the ratio in one check, for every phase value from 0 to 31 and every pair of high and low counts. The configuration inputs are scrambled halfway through each observation window, and one channel stays excluded throughout.

// File: rtl/pdiv_pkg.sv
`timescale 1ns/1ps
package pdiv_pkg;
  localparam int CNT_W = 4;
  localparam int PO_W  = 4;
  localparam int DLY_W = ((PO_W > CNT_W) ? PO_W : CNT_W) + 1;

  typedef struct packed {
    logic [CNT_W-1:0] hi;
    logic [CNT_W-1:0] lo;
  } pdiv_ratio_t;
endpackage

// File: rtl/pdiv_dly_calc.sv
`timescale 1ns/1ps
module pdiv_dly_calc
  import pdiv_pkg::*;
(
  input  logic             start_hi_i,
  input  logic [PO_W-1:0]  po_i,
  input  logic [CNT_W-1:0] lo_i,
  output logic [DLY_W-1:0] dly_o
);
  // start-high adds the low phase plus one cycle on top of the offset
  always_comb begin
    if (start_hi_i) dly_o = DLY_W'(po_i) + DLY_W'(lo_i) + DLY_W'(1);
    else            dly_o = DLY_W'(po_i);
  end
endmodule

// File: rtl/pdiv_cfg_hold.sv
`timescale 1ns/1ps
module pdiv_cfg_hold
  import pdiv_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        load_i,
  input  pdiv_ratio_t ratio_i,
  output pdiv_ratio_t ratio_o
);
  pdiv_ratio_t ratio_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     ratio_q <= '0;
    else if (load_i) ratio_q <= ratio_i;
  end

  assign ratio_o = ratio_q;
endmodule

// File: rtl/pdiv_core.sv
`timescale 1ns/1ps
module pdiv_core
  import pdiv_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             hold_i,
  input  logic [DLY_W-1:0] dly_i,
  input  logic [CNT_W-1:0] hi_i,
  input  logic [CNT_W-1:0] lo_i,
  output logic             div_o
);
  logic             out_q;
  logic             run_q;
  logic [DLY_W-1:0] dly_q;
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      out_q <= 1'b0;
      run_q <= 1'b0;
      dly_q <= '0;
      cnt_q <= '0;
    end else if (hold_i) begin
      out_q <= 1'b0;
      run_q <= 1'b0;
      dly_q <= dly_i;
      cnt_q <= '0;
    end else if (!run_q) begin
      if (dly_q == '0) begin
        out_q <= 1'b1;
        run_q <= 1'b1;
        cnt_q <= hi_i;
      end else begin
        dly_q <= dly_q - DLY_W'(1);
      end
    end else if (cnt_q == '0) begin
      out_q <= ~out_q;
      cnt_q <= out_q ? lo_i : hi_i;
    end else begin
      cnt_q <= cnt_q - CNT_W'(1);
    end
  end

  assign div_o = out_q;

  // checker state: segment length and wait since release
  logic             lvl_q;
  logic [CNT_W:0]   seg_q;
  logic [DLY_W-1:0] dly_cap_q;
  logic [DLY_W:0]   wait_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lvl_q     <= 1'b0;
      seg_q     <= '0;
      dly_cap_q <= '0;
      wait_q    <= '0;
    end else begin
      lvl_q <= out_q;
      seg_q <= (out_q != lvl_q) ? (CNT_W+1)'(1) : seg_q + (CNT_W+1)'(1);
      if (hold_i) begin
        dly_cap_q <= dly_i;
        wait_q    <= '0;
      end else if (!run_q) begin
        wait_q <= wait_q + (DLY_W+1)'(1);
      end
    end
  end

  AST_HOLD_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hold_i |=> !div_o); // R4

  AST_HI_LEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_q && lvl_q && !div_o) |-> (seg_q == {1'b0, hi_i} + (CNT_W+1)'(1))); // R3

  AST_LO_LEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_q && $past(run_q) && !lvl_q && div_o) |-> (seg_q == {1'b0, lo_i} + (CNT_W+1)'(1))); // R3

  AST_FIRST_RISE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(run_q) |-> (wait_q == {1'b0, dly_cap_q} + (DLY_W+1)'(1))); // R5 R6
endmodule

// File: rtl/phase_clk_div.sv
`timescale 1ns/1ps
module phase_clk_div
  import pdiv_pkg::*;
#(
  parameter int NUM_CH = 4
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    sync_i,
  input  logic                    sync_sw_i,
  input  logic [NUM_CH-1:0]       excl_i,
  input  logic [NUM_CH-1:0]       start_hi_i,
  input  logic [NUM_CH*PO_W-1:0]  phase_i,
  input  logic [NUM_CH*CNT_W-1:0] hi_cnt_i,
  input  logic [NUM_CH*CNT_W-1:0] lo_cnt_i,
  output logic [NUM_CH-1:0]       clk_o
);
  logic sync_req;
  assign sync_req = sync_i | sync_sw_i;

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    logic             hold;
    pdiv_ratio_t      live_r;
    pdiv_ratio_t      held_r;
    logic [DLY_W-1:0] dly;

    assign hold      = sync_req & ~excl_i[c];
    assign live_r.hi = hi_cnt_i[c*CNT_W +: CNT_W];
    assign live_r.lo = lo_cnt_i[c*CNT_W +: CNT_W];

    pdiv_dly_calc u_dly (
      .start_hi_i (start_hi_i[c]),
      .po_i       (phase_i[c*PO_W +: PO_W]),
      .lo_i       (live_r.lo),
      .dly_o      (dly)
    );

    pdiv_cfg_hold u_cfg (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .load_i  (hold),
      .ratio_i (live_r),
      .ratio_o (held_r)
    );

    pdiv_core u_core (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .hold_i (hold),
      .dly_i  (dly),
      .hi_i   (held_r.hi),
      .lo_i   (held_r.lo),
      .div_o  (clk_o[c])
    );
  end
endmodule

// File: tb/phase_clk_div_tb_top.sv
`timescale 1ns/1ps
module phase_clk_div_tb_top;
  localparam int NCH = 4;

  logic           clk_i = 1'b0;
  logic           rst_ni;
  logic           sync_i, sync_sw_i;
  logic [NCH-1:0] excl_v, sh_v, clk_o;
  logic [NCH*4-1:0] po_v, hi_v, lo_v;

  always #2 clk_i = ~clk_i;

  phase_clk_div #(.NUM_CH(NCH)) dut_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .sync_i(sync_i), .sync_sw_i(sync_sw_i),
    .excl_i(excl_v), .start_hi_i(sh_v), .phase_i(po_v),
    .hi_cnt_i(hi_v), .lo_cnt_i(lo_v), .clk_o(clk_o)
  );

  int checks = 0, errors = 0, cyc = 0;
  bit done = 0;
  int live_n[NCH], live_m[NCH], live_po[NCH], live_sh[NCH];
  int exp_n[NCH], exp_m[NCH], exp_d[NCH], rel_c[NCH];
  int mism[NCH], fa[NCH], fe[NCH];
  int mism7, hold_bad;

  function automatic int exp_out(int n, int m, int d, int t);
    if (t <= d) return 0;
    return (((t - 1 - d) % (n + m + 2)) <= n) ? 1 : 0;
  endfunction

  task automatic check(bit ok, string tag, int act, int expv, string what);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", tag, what, act, expv);
    end
  endtask

  task automatic step();
    @(negedge clk_i);
    cyc++;
  endtask

  task automatic push_live();
    for (int c = 0; c < NCH; c++) begin
      hi_v[c*4 +: 4] = 4'(live_n[c]);
      lo_v[c*4 +: 4] = 4'(live_m[c]);
      po_v[c*4 +: 4] = 4'(live_po[c]);
      sh_v[c]        = live_sh[c][0];
    end
  endtask

  task automatic clear_run();
    for (int c = 0; c < NCH; c++) begin
      mism[c] = 0; fa[c] = 0; fe[c] = 0;
    end
    mism7 = 0; hold_bad = 0;
  endtask

  task automatic cmp_ch(int c, bit track7);
    int e, a;
    e = exp_out(exp_n[c], exp_m[c], exp_d[c], cyc - rel_c[c]);
    a = int'(clk_o[c]);
    if (a != e) begin
      if (mism[c] == 0) begin fa[c] = a; fe[c] = e; end
      mism[c]++;
      if (track7 && c < 3) mism7++;
    end
  endtask

  task automatic sync_pulse(bit sw, int hc);
    if (sw) sync_sw_i = 1'b1; else sync_i = 1'b1;
    for (int k = 0; k < hc; k++) begin
      step();
      for (int c = 0; c < NCH; c++) begin
        if (excl_v[c]) cmp_ch(c, 1'b0);
        else if (clk_o[c] !== 1'b0) hold_bad++;
      end
    end
    sync_i = 1'b0; sync_sw_i = 1'b0;
    for (int c = 0; c < NCH; c++) begin
      if (!excl_v[c]) begin
        exp_n[c] = live_n[c];
        exp_m[c] = live_m[c];
        exp_d[c] = live_sh[c] != 0 ? live_po[c] + live_m[c] + 1 : live_po[c];
        rel_c[c] = cyc;
      end
    end
  endtask

  task automatic observe(int len, int scr);
    for (int t = 1; t <= len; t++) begin
      step();
      for (int c = 0; c < NCH; c++) cmp_ch(c, scr >= 0 && t > scr);
      if (t == scr) begin
        for (int c = 0; c < NCH; c++) begin
          live_n[c]  = (live_n[c] + 5) % 16;
          live_m[c]  = (live_m[c] + 9) % 16;
          live_po[c] = (live_po[c] + 7) % 16;
          live_sh[c] = 1 - live_sh[c];
        end
        push_live();
      end
    end
  endtask

  initial begin
    rst_ni = 1'b0; sync_i = 1'b0; sync_sw_i = 1'b0; excl_v = '0;
    for (int c = 0; c < NCH; c++) begin
      live_n[c] = 0; live_m[c] = 0; live_po[c] = 0; live_sh[c] = 0;
      exp_n[c] = 0; exp_m[c] = 0; exp_d[c] = 0; rel_c[c] = 0;
    end
    push_live();
    for (int k = 0; k < 3; k++) begin
      step();
      check(clk_o == '0, "R1", int'(clk_o), 0, "output during reset");
    end
    rst_ni = 1'b1;
    for (int c = 0; c < NCH; c++) rel_c[c] = cyc;
    clear_run();
    observe(20, -1);
    for (int c = 0; c < NCH; c++)
      check(mism[c] == 0, "R2", fa[c], fe[c], $sformatf("div-by-2 after reset ch%0d", c));

    // initial capture on all channels, then park channel 3 as excluded
    live_n[3] = 2; live_m[3] = 1; live_po[3] = 3; live_sh[3] = 0;
    live_n[1] = 1; live_m[1] = 2; live_po[1] = 9; live_sh[1] = 1;
    push_live();
    clear_run();
    sync_pulse(1'b0, 2);
    check(hold_bad == 0, "R4", hold_bad, 0, "outputs not low during sync");
    observe(40, -1);
    for (int c = 0; c < NCH; c++)
      check(mism[c] == 0, c == 1 ? "R6" : "R5", fa[c], fe[c], $sformatf("first sync ch%0d", c));
    excl_v[3] = 1'b1;

    for (int r = 0; r < 256; r++) begin
      int phi;
      phi = r % 32;
      live_n[0] = r % 3;   live_m[0] = r % 3;        live_po[0] = 0;       live_sh[0] = 0;
      live_n[1] = r % 7;   live_m[1] = (r * 7) % 16; live_po[1] = phi % 16; live_sh[1] = phi / 16;
      live_n[2] = r % 16;  live_m[2] = r / 16;       live_po[2] = 0;       live_sh[2] = 0;
      push_live();
      clear_run();
      sync_pulse(r[0], 2 + r % 3);
      check(hold_bad == 0, r[0] ? "R9" : "R4", hold_bad, 0, $sformatf("hold low run %0d", r));
      observe(100, 50);
      check(mism[0] == 0, "R3", fa[0], fe[0], $sformatf("ref ch0 run %0d", r));
      check(mism[1] == 0, phi < 16 ? "R5" : "R6", fa[1], fe[1], $sformatf("phase %0d ch1 run %0d", phi, r));
      check(mism[2] == 0, "R3", fa[2], fe[2], $sformatf("ratio ch2 run %0d", r));
      check(mism[3] == 0, "R8", fa[3], fe[3], $sformatf("excluded ch3 run %0d", r));
      check(mism7 == 0, "R7", mism7, 0, $sformatf("samples moved after live change run %0d", r));
    end

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog (all requirements): actual=%0d expected=%0d", cyc, 0);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule